// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits beside the fetch stage of a processor core and guesses where the next fetch should go. Every cycle the fetch address is looked up in a direct-mapped table. Each slot holds a valid bit, a tag, a branch target and a two-bit saturating history counter. A hit whose counter leans towards taken returns the stored target as the next fetch address. Any other lookup returns the next sequential word.

When a branch resolves later in the pipeline, the core presents the branch address, the real target and the real outcome on the update port. If the branch is already in the table, its counter moves one step towards the outcome. A taken branch that is not in the table claims its slot and starts out in the strongly-not-taken state. In the same cycle the block reports whether the table's guess for that branch matched the real next address.

A global enable freezes the table and forces sequential prediction. A one-cycle flush input invalidates every slot.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid. Every lookup then reports no hit and a next address of the fetch address plus 4.
- R2: The slot index is address bits [8:2] and the tag is bits [31:9]. A lookup hits only when the slot is valid and its stored tag equals the tag of the address.
- R3: On a hit whose history is weakly or strongly taken, the next address is the stored target and `fetch_taken` is 1. On any other lookup the next address is the fetch address plus 4 and `fetch_taken` is 0.
- R4: History encoding: 0 is strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. An update that hits adds 1 when taken and subtracts 1 when not taken, saturating at 3 and 0.
- R5: A taken update that misses writes the tag and target into its slot with history 0 and valid set, replacing whatever the slot held before.
- R6: A not-taken update that misses leaves the table unchanged.
- R7: While `enable` is 0, `fetch_hit` and `fetch_taken` are 0, the next address is sequential, and updates leave the table unchanged.
- R8: A flush invalidates every slot in one cycle. If a flush and an update arrive in the same cycle, the flush wins and nothing is allocated.
- R9: `upd_correct` is 1 when `upd_valid` is 1 and the table's prediction for `upd_pc`, taken from the state before the update, equals the real next address: the target if taken, `upd_pc`+4 if not. Otherwise it is 0.
- R10: A taken update that hits also replaces the stored target with `upd_target`.
- R11: A lookup made in the same cycle as an update to the same slot sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns prediction and table writes on |
| flush | input | 1 | Invalidates all slots at the next edge |
| fetch_pc | input | 32 | Address being fetched |
| fetch_hit | output | 1 | Lookup found a valid matching slot |
| fetch_taken | output | 1 | Prediction is taken |
| fetch_next | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Real target of the branch |
| upd_taken | input | 1 | Real outcome of the branch |
| upd_correct | output | 1 | The table's guess for this branch was right |

## Verification
Two pairs of functions can fall in the same cycle.

- **Flush and update.** The bench raises `flush` in the same cycle as a taken update that would allocate. It then looks up every slot, and each lookup must miss.
- **Lookup and update on one slot.** The bench drives a lookup and an update to the same slot together. It samples the lookup before the clock edge and compares it with a model holding the state from before the update. The next lookup must show the counter after the update.

A long random phase confines addresses to a few slots and tags, so that these overlaps and tag collisions recur.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_e;

endpackage

// File: rtl/btb_hist_step.sv
module btb_hist_step
    import btb_pkg::*;
(
    input  hist_e cur,
    input  logic  taken,
    output hist_e nxt
);

    always_comb begin
        nxt = cur;
        if (taken) begin
            if (cur != HIST_ST) nxt = hist_e'(cur + 2'd1);
        end else begin
            if (cur != HIST_SNT) nxt = hist_e'(cur - 2'd1);
        end
    end

endmodule

// File: rtl/btb_probe.sv
module btb_probe
    import btb_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int IDX_W  = 7,
    localparam int TAG_W  = ADDR_W - IDX_W - 2,
    localparam int TGT_W  = ADDR_W - 2
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] pc,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    input  logic [TGT_W-1:0]  ent_tgt,
    input  hist_e             ent_hist,
    output logic              hit,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);

    logic [TGT_W-1:0] seq_word;

    always_comb begin
        seq_word = pc[ADDR_W-1:2] + 1'b1;
        hit      = enable && ent_valid && (ent_tag == pc[ADDR_W-1:IDX_W+2]);
        taken    = hit && ent_hist[1];
        next_pc  = taken ? {ent_tgt, 2'b00} : {seq_word, 2'b00};
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_hit,
    output logic              fetch_taken,
    output logic [ADDR_W-1:0] fetch_next,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              upd_taken,
    output logic              upd_correct
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int TGT_W = ADDR_W - 2;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [TGT_W-1:0] tgt;
        hist_e            hist;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
    } state_t;

    state_t state_q, state_d;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] u_tag;
    logic              u_hit, u_pred_taken;
    logic [ADDR_W-1:0] u_pred_next, u_real_next;
    hist_e             u_hist_nxt;

    assign f_idx = fetch_pc[IDX_W+1:2];
    assign u_idx = upd_pc[IDX_W+1:2];
    assign u_tag = upd_pc[ADDR_W-1:IDX_W+2];

    // Read port for the fetch stage
    btb_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch_probe (
        .enable    (enable),
        .pc        (fetch_pc),
        .ent_valid (state_q.tbl[f_idx].valid),
        .ent_tag   (state_q.tbl[f_idx].tag),
        .ent_tgt   (state_q.tbl[f_idx].tgt),
        .ent_hist  (state_q.tbl[f_idx].hist),
        .hit       (fetch_hit),
        .taken     (fetch_taken),
        .next_pc   (fetch_next)
    );

    // Read port for the resolving branch
    btb_probe #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_probe (
        .enable    (enable),
        .pc        (upd_pc),
        .ent_valid (state_q.tbl[u_idx].valid),
        .ent_tag   (state_q.tbl[u_idx].tag),
        .ent_tgt   (state_q.tbl[u_idx].tgt),
        .ent_hist  (state_q.tbl[u_idx].hist),
        .hit       (u_hit),
        .taken     (u_pred_taken),
        .next_pc   (u_pred_next)
    );

    btb_hist_step u_step (
        .cur   (state_q.tbl[u_idx].hist),
        .taken (upd_taken),
        .nxt   (u_hist_nxt)
    );

    always_comb begin
        u_real_next = upd_taken ? upd_target : (upd_pc + ADDR_W'(4));
        upd_correct = upd_valid && (u_pred_next == u_real_next);
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_d.tbl[i].valid = 1'b0;
            end
        end else if (upd_valid && enable) begin
            if (u_hit) begin
                state_d.tbl[u_idx].hist = u_hist_nxt;
                if (upd_taken) state_d.tbl[u_idx].tgt = upd_target[ADDR_W-1:2];
            end else if (upd_taken) begin
                state_d.tbl[u_idx].valid = 1'b1;
                state_d.tbl[u_idx].tag   = u_tag;
                state_d.tbl[u_idx].tgt   = upd_target[ADDR_W-1:2];
                state_d.tbl[u_idx].hist  = HIST_SNT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !fetch_hit); // R8

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !flush) |=> state_q.tbl == $past(state_q.tbl)); // R7

    AST_ALLOC_SNT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && enable && !flush && upd_taken && !u_hit)
        |=> (state_q.tbl[$past(u_idx)].valid && state_q.tbl[$past(u_idx)].hist == HIST_SNT)); // R5

    AST_NT_MISS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && enable && !flush && !upd_taken && !u_hit)
        |=> state_q.tbl[$past(u_idx)] == $past(state_q.tbl[u_idx])); // R6

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && enable && !flush && u_hit && upd_taken && state_q.tbl[u_idx].hist == HIST_ST)
        |=> state_q.tbl[$past(u_idx)].hist == HIST_ST); // R4

    AST_CORRECT_TAKEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_correct && upd_taken) |-> u_pred_taken); // R9

endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        flush = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_hit, fetch_taken;
    logic [31:0] fetch_next;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [31:0] upd_target = '0;
    logic        upd_taken = 1'b0;
    logic        upd_correct;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model of the table
    bit          m_v   [N];
    logic [22:0] m_tag [N];
    logic [31:0] m_tgt [N];
    int          m_h   [N];
    bit          m_en = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush),
        .fetch_pc(fetch_pc), .fetch_hit(fetch_hit), .fetch_taken(fetch_taken),
        .fetch_next(fetch_next), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_target(upd_target), .upd_taken(upd_taken), .upd_correct(upd_correct)
    );

    function automatic logic [31:0] mk(int tag, int idx);
        return (tag << 9) | ((idx % N) << 2);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void m_pred(logic [31:0] pc, output bit hit, output bit tk,
                                   output logic [31:0] nxt);
        int i;
        i   = (pc >> 2) % N;
        hit = m_en && m_v[i] && (m_tag[i] == pc[31:9]);
        tk  = hit && (m_h[i] >= 2);
        nxt = tk ? m_tgt[i] : pc + 32'd4;
    endfunction

    function automatic void m_apply(bit fl, bit uv, logic [31:0] pc, logic [31:0] tgt, bit tk);
        int i;
        bit hit, ptk;
        logic [31:0] pn;
        if (fl) begin
            for (int k = 0; k < N; k++) m_v[k] = 1'b0;
            return;
        end
        if (!uv || !m_en) return;
        i = (pc >> 2) % N;
        m_pred(pc, hit, ptk, pn);
        if (hit) begin
            if (tk) begin
                if (m_h[i] < 3) m_h[i]++;
                m_tgt[i] = tgt;
            end else if (m_h[i] > 0) m_h[i]--;
        end else if (tk) begin
            m_v[i] = 1'b1; m_tag[i] = pc[31:9]; m_tgt[i] = tgt; m_h[i] = 0;
        end
    endfunction

    // One cycle: drive lookup and optional update/flush, check before the edge
    task automatic step(logic [31:0] fpc, bit uv, logic [31:0] upc, logic [31:0] utgt,
                        bit utk, bit fl, string req);
        bit eh, et, uh, ut;
        logic [31:0] en, un, real_next;
        @(negedge clk);
        fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
        upd_target = utgt; upd_taken = utk; flush = fl;
        #1;
        m_pred(fpc, eh, et, en);
        chk(fetch_hit == eh, req, "fetch_hit", 32'(fetch_hit), 32'(eh));
        chk(fetch_taken == et, req, "fetch_taken", 32'(fetch_taken), 32'(et));
        chk(fetch_next == en, req, "fetch_next", fetch_next, en);
        m_pred(upc, uh, ut, un);
        real_next = utk ? utgt : upc + 32'd4;
        chk(upd_correct == (uv && un == real_next), "R9", "upd_correct",
            32'(upd_correct), 32'(uv && un == real_next));
        @(posedge clk);
        m_apply(fl, uv, upc, utgt, utk);
        #1;
        upd_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic set_en(bit v);
        @(negedge clk);
        enable = v; m_en = v;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            m_v[k] = 0; m_tag[k] = '0; m_tgt[k] = '0; m_h[k] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty table after reset
        for (int k = 0; k < 8; k++) step(mk(k * 3, k * 17), 0, '0, '0, 0, 0, "R1");

        // R5: first taken branch allocates every slot
        for (int k = 0; k < N; k++)
            step(mk(k + 1, k), 1, mk(k + 1, k), 32'(k * 64 + 32'h1000_0000), 1, 0, "R5");
        // R3: freshly allocated slots hit but predict sequential
        for (int k = 0; k < N; k++) step(mk(k + 1, k), 0, '0, '0, 0, 0, "R3");

        // R4: walk slot 5 up past saturation, then down past the floor
        for (int k = 0; k < 5; k++) step(mk(6, 5), 1, mk(6, 5), 32'h0000_4000, 1, 0, "R4");
        step(mk(6, 5), 0, '0, '0, 0, 0, "R4");
        for (int k = 0; k < 5; k++) step(mk(6, 5), 1, mk(6, 5), 32'h0000_4000, 0, 0, "R4");
        step(mk(6, 5), 1, mk(6, 5), 32'h0000_4000, 1, 0, "R4");
        step(mk(6, 5), 0, '0, '0, 0, 0, "R4");

        // R2: different tag on the same index misses
        step(mk(99, 5), 0, '0, '0, 0, 0, "R2");
        // R6: not-taken miss leaves the old owner in place
        step(mk(6, 5), 1, mk(99, 5), 32'h0000_8000, 0, 0, "R6");
        step(mk(6, 5), 0, '0, '0, 0, 0, "R6");
        // R5: taken miss replaces the owner; R2: old tag now misses
        step(mk(99, 5), 1, mk(99, 5), 32'h0000_8000, 1, 0, "R5");
        step(mk(6, 5), 0, '0, '0, 0, 0, "R2");

        // R10: taken hits rewrite the target
        step(mk(99, 5), 1, mk(99, 5), 32'h0000_A000, 1, 0, "R10");
        step(mk(99, 5), 1, mk(99, 5), 32'h0000_C000, 1, 0, "R10");
        step(mk(99, 5), 0, '0, '0, 0, 0, "R10");

        // R11: lookup and update on one slot in the same cycle
        step(mk(99, 5), 1, mk(99, 5), 32'h0000_C000, 0, 0, "R11");
        step(mk(99, 5), 0, '0, '0, 0, 0, "R11");

        // R7: disabled block predicts sequential and ignores updates
        set_en(0);
        step(mk(2, 1), 1, mk(77, 40), 32'h0000_E000, 1, 0, "R7");
        step(mk(2, 1), 1, mk(2, 1), 32'h0000_E000, 1, 0, "R7");
        set_en(1);
        step(mk(77, 40), 0, '0, '0, 0, 0, "R7");
        step(mk(2, 1), 0, '0, '0, 0, 0, "R7");

        // R8: flush beats a same-cycle allocation, then every slot misses
        step(mk(3, 2), 1, mk(55, 2), 32'h0000_F000, 1, 1, "R8");
        for (int k = 0; k < N; k++) step(mk(k + 1, k), 0, '0, '0, 0, 0, "R8");
        step(mk(55, 2), 0, '0, '0, 0, 0, "R8");

        // R3: random traffic over a few slots and tags
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r == 0) set_en(!m_en);
            step(mk(int'($urandom % 3), int'($urandom % 6)),
                 bit'($urandom % 4 != 0),
                 mk(int'($urandom % 3), int'($urandom % 6)),
                 {$urandom % 16, 2'b00} << 4,
                 bit'($urandom % 2), r == 1, "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule